// File: doc/BRIEF.md
# Banked Byte-Read User ROM with Bank Programmer

This block holds a small nonvolatile user store of 1024 bits, split into eight banks of 128 bits. Logic on the chip reads it one byte at a time through a synchronous read port. The port takes a 7-bit address on a rising clock edge and launches the addressed byte on the next falling edge. The read port cannot alter the contents.

Contents change only through a separate programming port, and only one whole bank at a time. A request names a bank and supplies 128 bits of data. The program sequencer first erases that bank to all ones, which takes `ERASE_CYC` cycles. It then spends `PROG_CYC` cycles programming and commits the new word on the last of them. The sequencer has three states:
- `SQ_IDLE` moves to `SQ_ERASE` when `pg_req` is seen.
- `SQ_ERASE` moves to `SQ_PROGRAM` after `ERASE_CYC` cycles.
- `SQ_PROGRAM` moves back to `SQ_IDLE` after `PROG_CYC` cycles, and the word is written into the bank on that final transition.

Reset clears only the output stage and the sequencer. The stored banks keep their values through reset.

Top module: `flash_user_rom`

## Requirements
- R1: Read address bits [6:4] select the bank, and bits [3:0] select byte k of that bank. Byte k is bits [8k+7:8k] of the 128-bit word that was programmed into the bank.
- R2: An address present at a rising edge produces its byte on `rd_data` at the next falling edge. `rd_valid` is low from each rising edge to the following falling edge and high from that falling edge to the next rising edge. This holds even when the address does not change.
- R3: While `rst_n` is low, `rd_data` is 0, `rd_valid` is 0 and `pg_busy` is 0. Bank contents programmed before reset read back unchanged after reset.
- R4: A `pg_req` seen at a rising edge while `pg_busy` is low is accepted. `pg_busy` is high right after that edge and stays high for exactly `ERASE_CYC`+`PROG_CYC` cycles (4+8 = 12 by default).
- R5: From the acceptance edge until completion, every byte of the target bank reads as 8'hFF.
- R6: After completion, the target bank reads the new 128-bit word. Every other bank keeps its previous contents, including while the operation is running.
- R7: A `pg_req` raised while `pg_busy` is high is ignored. The bank it names and the operation in progress are both unaffected.
- R8: The sequencer passes through `SQ_IDLE`, `SQ_ERASE`, `SQ_PROGRAM` and back to `SQ_IDLE`. The erase write and the program commit never happen in the same cycle, and `pg_busy` is low in the cycle after the commit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; address is taken on the rising edge, data launched on the falling edge |
| rst_n | input | 1 | Asynchronous active-low reset of output stage and sequencer |
| rd_addr | input | 7 | Read byte address: [6:4] bank, [3:0] byte |
| rd_data | output | 8 | Read byte, updated on the falling edge |
| rd_valid | output | 1 | High while `rd_data` holds the byte for the address last sampled |
| pg_req | input | 1 | Request to reprogram one whole bank |
| pg_bank | input | 3 | Bank to reprogram |
| pg_word | input | 128 | New contents of the bank |
| pg_busy | output | 1 | High from request acceptance until the new word is committed |

## Verification
The hardest case to reach is a read of the target bank while its operation is still running, combined with a second request that arrives in the middle of that operation. The stimulus issues a program request and then reads the target bank within the busy window. At the same time it raises `pg_req` toward another bank that already holds known data. Once busy drops, both banks are read back. Further random programs and random reads check the bank and byte decoding against a model of the banks kept in the bench.

// File: rtl/fur_pkg.sv
package fur_pkg;
    typedef enum logic [1:0] {
        SQ_IDLE    = 2'd0,
        SQ_ERASE   = 2'd1,
        SQ_PROGRAM = 2'd2
    } seq_state_t;
endpackage

// File: rtl/fur_array.sv
module fur_array #(
    parameter int BANKS     = 8,
    parameter int BANK_BITS = 128,
    parameter int BYTE_W    = 8,
    localparam int BYTES_PER_BANK = BANK_BITS / BYTE_W,
    localparam int BANK_AW = $clog2(BANKS),
    localparam int BYTE_AW = $clog2(BYTES_PER_BANK)
) (
    input  logic                 clk,
    input  logic                 erase_we,
    input  logic                 prog_we,
    input  logic [BANK_AW-1:0]   wr_bank,
    input  logic [BANK_BITS-1:0] wr_word,
    input  logic [BANK_AW-1:0]   rd_bank,
    input  logic [BYTE_AW-1:0]   rd_byte,
    output logic [BYTE_W-1:0]    rd_byte_data
);
    logic [BANK_BITS-1:0] bank_words [BANKS];

    // Storage has no reset: contents survive reset like a nonvolatile array.
    for (genvar g = 0; g < BANKS; g++) begin : g_bank
        logic [BANK_BITS-1:0] cells_q;
        logic                 hit;
        assign hit = (wr_bank == BANK_AW'(g));
        always_ff @(posedge clk) begin
            if (erase_we && hit) begin
                cells_q <= '1;
            end else if (prog_we && hit) begin
                cells_q <= wr_word;
            end
        end
        assign bank_words[g] = cells_q;
    end

    always_comb begin
        rd_byte_data = bank_words[rd_bank][rd_byte*BYTE_W +: BYTE_W];
    end
endmodule

// File: rtl/fur_seq.sv
module fur_seq
    import fur_pkg::*;
#(
    parameter int BANKS     = 8,
    parameter int BANK_BITS = 128,
    parameter int ERASE_CYC = 4,
    parameter int PROG_CYC  = 8,
    localparam int BANK_AW  = $clog2(BANKS),
    localparam int MAX_CYC  = (ERASE_CYC > PROG_CYC) ? ERASE_CYC : PROG_CYC,
    localparam int CW       = $clog2(MAX_CYC + 1)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 pg_req,
    input  logic [BANK_AW-1:0]   pg_bank,
    input  logic [BANK_BITS-1:0] pg_word,
    output logic                 busy,
    output logic                 erase_we,
    output logic                 prog_we,
    output logic [BANK_AW-1:0]   wr_bank,
    output logic [BANK_BITS-1:0] wr_word,
    output logic [BANK_AW-1:0]   held_bank
);
    localparam logic [CW-1:0] ERASE_LAST = CW'(ERASE_CYC - 1);
    localparam logic [CW-1:0] PROG_LAST  = CW'(PROG_CYC - 1);

    seq_state_t           state_q, state_d;
    logic [CW-1:0]        cnt_q, cnt_d;
    logic [BANK_AW-1:0]   bank_q;
    logic [BANK_BITS-1:0] word_q;
    logic                 accept;

    // State register process
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= SQ_IDLE;
            cnt_q   <= '0;
            bank_q  <= '0;
            word_q  <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
            if (accept) begin
                bank_q <= pg_bank;
                word_q <= pg_word;
            end
        end
    end

    // Next state and outputs
    always_comb begin
        state_d  = state_q;
        cnt_d    = cnt_q;
        accept   = 1'b0;
        erase_we = 1'b0;
        prog_we  = 1'b0;
        busy     = 1'b1;
        unique case (state_q)
            SQ_IDLE: begin
                busy = 1'b0;
                if (pg_req) begin
                    accept   = 1'b1;
                    erase_we = 1'b1;
                    state_d  = SQ_ERASE;
                    cnt_d    = '0;
                end
            end
            SQ_ERASE: begin
                if (cnt_q == ERASE_LAST) begin
                    state_d = SQ_PROGRAM;
                    cnt_d   = '0;
                end else begin
                    cnt_d = cnt_q + 1'b1;
                end
            end
            SQ_PROGRAM: begin
                if (cnt_q == PROG_LAST) begin
                    prog_we = 1'b1;
                    state_d = SQ_IDLE;
                    cnt_d   = '0;
                end else begin
                    cnt_d = cnt_q + 1'b1;
                end
            end
            default: begin
                state_d = SQ_IDLE;
                cnt_d   = '0;
            end
        endcase
    end

    assign wr_bank   = accept ? pg_bank : bank_q;
    assign wr_word   = word_q;
    assign held_bank = bank_q;
endmodule

// File: rtl/fur_rdpipe.sv
module fur_rdpipe #(
    parameter int AW     = 7,
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [AW-1:0]     rd_addr,
    input  logic [BYTE_W-1:0] byte_in,
    output logic [AW-1:0]     addr_q,
    output logic [BYTE_W-1:0] rd_data,
    output logic              rd_valid
);
    logic pos_tag, neg_tag, primed;

    // Rising edge: take the address and open the invalid window.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr_q  <= '0;
            pos_tag <= 1'b0;
        end else begin
            addr_q  <= rd_addr;
            pos_tag <= ~pos_tag;
        end
    end

    // Falling edge: launch the byte and close the invalid window.
    always_ff @(negedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_data <= '0;
            neg_tag <= 1'b0;
            primed  <= 1'b0;
        end else begin
            rd_data <= byte_in;
            neg_tag <= pos_tag;
            primed  <= 1'b1;
        end
    end

    assign rd_valid = primed && (neg_tag == pos_tag);
endmodule

// File: rtl/flash_user_rom.sv
module flash_user_rom #(
    parameter int BANKS     = 8,
    parameter int BANK_BITS = 128,
    parameter int BYTE_W    = 8,
    parameter int ERASE_CYC = 4,
    parameter int PROG_CYC  = 8,
    localparam int BYTES_PER_BANK = BANK_BITS / BYTE_W,
    localparam int BANK_AW = $clog2(BANKS),
    localparam int BYTE_AW = $clog2(BYTES_PER_BANK),
    localparam int AW      = BANK_AW + BYTE_AW
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [AW-1:0]        rd_addr,
    output logic [BYTE_W-1:0]    rd_data,
    output logic                 rd_valid,
    input  logic                 pg_req,
    input  logic [BANK_AW-1:0]   pg_bank,
    input  logic [BANK_BITS-1:0] pg_word,
    output logic                 pg_busy
);
    logic                 arr_erase_we, arr_prog_we;
    logic [BANK_AW-1:0]   arr_wr_bank, seq_bank_h;
    logic [BANK_BITS-1:0] arr_wr_word;
    logic [AW-1:0]        addr_q;
    logic [BYTE_W-1:0]    sel_byte;

    fur_seq #(
        .BANKS(BANKS), .BANK_BITS(BANK_BITS),
        .ERASE_CYC(ERASE_CYC), .PROG_CYC(PROG_CYC)
    ) u_seq (
        .clk(clk), .rst_n(rst_n),
        .pg_req(pg_req), .pg_bank(pg_bank), .pg_word(pg_word),
        .busy(pg_busy), .erase_we(arr_erase_we), .prog_we(arr_prog_we),
        .wr_bank(arr_wr_bank), .wr_word(arr_wr_word), .held_bank(seq_bank_h)
    );

    fur_array #(
        .BANKS(BANKS), .BANK_BITS(BANK_BITS), .BYTE_W(BYTE_W)
    ) u_array (
        .clk(clk),
        .erase_we(arr_erase_we), .prog_we(arr_prog_we),
        .wr_bank(arr_wr_bank), .wr_word(arr_wr_word),
        .rd_bank(addr_q[AW-1:BYTE_AW]), .rd_byte(addr_q[BYTE_AW-1:0]),
        .rd_byte_data(sel_byte)
    );

    fur_rdpipe #(
        .AW(AW), .BYTE_W(BYTE_W)
    ) u_rdpipe (
        .clk(clk), .rst_n(rst_n),
        .rd_addr(rd_addr), .byte_in(sel_byte),
        .addr_q(addr_q), .rd_data(rd_data), .rd_valid(rd_valid)
    );
endmodule

// File: rtl/flash_user_rom_chk.sv
module flash_user_rom_chk #(
    parameter int BANK_AW   = 3,
    parameter int ERASE_CYC = 4,
    parameter int PROG_CYC  = 8
) (
    input logic               clk,
    input logic               rst_n,
    input logic               pg_req,
    input logic               pg_busy,
    input logic               rd_valid,
    input logic               erase_we,
    input logic               prog_we,
    input logic [BANK_AW-1:0] held_bank
);
    logic [15:0] busy_cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            busy_cnt <= '0;
        end else if (pg_busy) begin
            busy_cnt <= busy_cnt + 16'd1;
        end else begin
            busy_cnt <= '0;
        end
    end

    // R4
    accept_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pg_req && !pg_busy) |=> pg_busy);

    // R4
    busy_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(pg_busy) |-> (busy_cnt == 16'(ERASE_CYC + PROG_CYC)));

    // R7
    held_bank_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pg_busy && $past(pg_busy)) |-> $stable(held_bank));

    // R8
    we_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({erase_we, prog_we}));

    // R8
    commit_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        prog_we |=> !pg_busy);

    // R2
    valid_before_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> rd_valid);
endmodule

bind flash_user_rom flash_user_rom_chk #(
    .BANK_AW(BANK_AW), .ERASE_CYC(ERASE_CYC), .PROG_CYC(PROG_CYC)
) u_chk (
    .clk(clk), .rst_n(rst_n), .pg_req(pg_req), .pg_busy(pg_busy),
    .rd_valid(rd_valid), .erase_we(arr_erase_we), .prog_we(arr_prog_we),
    .held_bank(seq_bank_h)
);

// File: tb/flash_user_rom_test.sv
module flash_user_rom_test;
    localparam int ERASE_CYC = 4;
    localparam int PROG_CYC  = 8;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [6:0]   rd_addr = '0;
    logic [7:0]   rd_data;
    logic         rd_valid;
    logic         pg_req = 1'b0;
    logic [2:0]   pg_bank = '0;
    logic [127:0] pg_word = '0;
    logic         pg_busy;

    logic [127:0] model [8];
    int n_chk = 0;
    int n_fail = 0;

    flash_user_rom #(.ERASE_CYC(ERASE_CYC), .PROG_CYC(PROG_CYC)) uut (
        .clk(clk), .rst_n(rst_n), .rd_addr(rd_addr), .rd_data(rd_data),
        .rd_valid(rd_valid), .pg_req(pg_req), .pg_bank(pg_bank),
        .pg_word(pg_word), .pg_busy(pg_busy)
    );

    always #5 clk = ~clk;

    function automatic logic [7:0] exp_byte(input logic [6:0] a);
        return model[a[6:4]][a[3:0]*8 +: 8];
    endfunction

    function automatic logic [127:0] rnd_word();
        return {$urandom, $urandom, $urandom, $urandom};
    endfunction

    task automatic check(input bit ok, input string req, input logic [127:0] act, input logic [127:0] expv);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
        end
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    // Read one byte; data checked after the falling edge, invalid window after the next rising edge.
    task automatic read_chk(input logic [6:0] a, input logic [7:0] expv, input string req);
        @(negedge clk); #1 rd_addr = a;
        @(posedge clk);
        @(negedge clk); #2;
        check(rd_data === expv, req, rd_data, expv);
        check(rd_valid === 1'b1, "R2 valid after fall", rd_valid, 1);
        @(posedge clk); #2;
        check(rd_valid === 1'b0, "R2 invalid after rise", rd_valid, 0);
    endtask

    task automatic program_bank(input logic [2:0] b, input logic [127:0] w);
        int n;
        @(negedge clk); #1 pg_req = 1'b1; pg_bank = b; pg_word = w;
        @(posedge clk); #1 pg_req = 1'b0;
        n = 0;
        while (pg_busy && n < 1000) begin
            @(posedge clk); #1; n++;
        end
        check(n == ERASE_CYC + PROG_CYC, "R4 busy length", n, ERASE_CYC + PROG_CYC);
        model[b] = w;
    endtask

    initial begin
        #2_000_000;
        n_chk++; n_fail++;
        $display("FAIL watchdog expired actual=hung expected=done");
        summary();
    end

    initial begin
        logic [127:0] w;
        void'($urandom(32'd20240611));
        // R3 reset state
        #2;
        check(rd_data === 8'h00, "R3 rd_data in reset", rd_data, 0);
        check(rd_valid === 1'b0, "R3 rd_valid in reset", rd_valid, 0);
        check(pg_busy === 1'b0, "R3 busy in reset", pg_busy, 0);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // Load every bank; R1 pattern on bank 5: byte k = {k, ~k}
        for (int b = 0; b < 8; b++) begin
            w = rnd_word();
            if (b == 5) for (int k = 0; k < 16; k++) w[k*8 +: 8] = {4'(k), ~4'(k)};
            program_bank(3'(b), w);
        end
        for (int k = 0; k < 16; k++)
            read_chk({3'd5, 4'(k)}, {4'(k), ~4'(k)}, "R1 byte lane decode");
        read_chk(7'h7F, exp_byte(7'h7F), "R1 top byte of bank 7");
        read_chk(7'h00, exp_byte(7'h00), "R1 bottom byte of bank 0");

        // R2 constant address: refreshed every cycle
        for (int i = 0; i < 3; i++) read_chk(7'h2A, exp_byte(7'h2A), "R2 constant address");

        // R5/R6/R7: reads during operation and a request while busy
        w = rnd_word();
        @(negedge clk); #1 pg_req = 1'b1; pg_bank = 3'd3; pg_word = w;
        @(posedge clk); #1 pg_req = 1'b0;
        check(pg_busy === 1'b1, "R4 busy after accept", pg_busy, 1);
        read_chk(7'h35, 8'hFF, "R5 erased byte during erase");
        @(negedge clk); #1 pg_req = 1'b1; pg_bank = 3'd6; pg_word = ~model[6];
        @(posedge clk); #1 pg_req = 1'b0;
        read_chk(7'h6C, exp_byte(7'h6C), "R7 named bank untouched while busy");
        read_chk(7'h10, exp_byte(7'h10), "R6 other bank during operation");
        read_chk(7'h3F, 8'hFF, "R5 erased byte during program");
        while (pg_busy) begin @(posedge clk); #1; end
        model[3] = w;
        check(pg_busy === 1'b0, "R8 back to idle", pg_busy, 0);
        for (int k = 0; k < 16; k++)
            read_chk({3'd3, 4'(k)}, exp_byte({3'd3, 4'(k)}), "R6 new word visible");
        for (int k = 0; k < 16; k++)
            read_chk({3'd6, 4'(k)}, exp_byte({3'd6, 4'(k)}), "R7 ignored request");

        // R3 reset keeps contents
        @(negedge clk); rst_n = 1'b0; #2;
        check(rd_data === 8'h00, "R3 rd_data cleared", rd_data, 0);
        check(rd_valid === 1'b0, "R3 rd_valid cleared", rd_valid, 0);
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        for (int b = 0; b < 8; b++)
            read_chk({3'(b), 4'(b + 2)}, exp_byte({3'(b), 4'(b + 2)}), "R3 contents kept");

        // Random programs and reads
        for (int j = 0; j < 6; j++) begin
            program_bank(3'($urandom_range(0, 7)), rnd_word());
            for (int i = 0; i < 25; i++) begin
                logic [6:0] a;
                a = 7'($urandom);
                read_chk(a, exp_byte(a), "R1 random read");
            end
        end
        summary();
    end
endmodule